// File: doc/BRIEF.md
# Serial Interface Baud Clock Generator

This block derives the timing strobes of a serial communication interface from the system clock. A selectable divide-by-1 or divide-by-8 prescaler feeds a 12-bit programmable divider, and a fixed divide-by-2 follows it. The result is the serial clock, which leaves the block as a one-cycle enable pulse. In asynchronous mode the same pulse is also exported as the 16x oversampling tick for the transmitter and the receiver. No stage produces a derived clock. Every stage is a counter that emits single-cycle enables in the system clock domain.

The external serial clock pin is produced as a registered 50% duty toggle. In synchronous mode it runs at half the serial clock rate. In asynchronous mode it runs at one sixteenth of the serial clock rate, which is the bit rate, or at the full serial clock rate, which is 16x the bit rate; a control bit chooses between the two. The pin's output enable is asserted only while the block is the clock master for both directions.

Divider and prescaler settings are picked up only when the affected counter reaches its terminal count, so a change never truncates a period in progress. A hardware reset and a synchronous software reset both clear all counters and outputs.

Top module: `sci_baud_gen`

## Requirements
- R1: The programmable divider divides by `div_ratio + 1`. A value of 0x000 gives divide-by-1 and 0xFFF gives divide-by-4096.
- R2: `pre_sel` = 0 selects a divide-by-1 prescaler and `pre_sel` = 1 selects divide-by-8, placed ahead of the programmable divider.
- R3: `ser_clk_en` is a one-cycle pulse repeating every T = 2 × P × (`div_ratio` + 1) system clock cycles, where P is the prescale ratio.
- R4: In asynchronous mode (`sync_mode` = 0), `tick_x16` pulses in exactly the cycles where `ser_clk_en` pulses. In synchronous mode it stays low.
- R5: In synchronous mode (`sync_mode` = 1), `sclk_out` toggles once per `ser_clk_en` pulse, giving a period of 2T whatever the value of `out_fast`.
- R6: In asynchronous mode with `out_fast` = 0, `sclk_out` toggles every 8 serial clock pulses, giving a period of 16T (the 1x bit rate).
- R7: In asynchronous mode with `out_fast` = 1, `sclk_out` has a period of T (the 16x bit rate), with both half periods equal to T/2.
- R8: `sclk_oe` is 1 one cycle after `tx_ext_clk` and `rx_ext_clk` are both 0, and 0 one cycle after either of them is 1.
- R9: While `rst` or `soft_rst` is high, all outputs are 0 from the next clock edge on. After release, the first `ser_clk_en` pulse appears on clock edge P × (`div_ratio` + 1) + 1.
- R10: A new `div_ratio` or `pre_sel` value is loaded only at the terminal count of its counter. A period already in progress runs to its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous active-high software reset |
| div_ratio | input | 12 | Programmable divide ratio minus one |
| pre_sel | input | 1 | Prescaler select: 0 = divide-by-1, 1 = divide-by-8 |
| out_fast | input | 1 | Asynchronous mode: 1 = SCLK at serial clock rate, 0 = divide-by-16 |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| tx_ext_clk | input | 1 | Transmit side takes its clock from outside |
| rx_ext_clk | input | 1 | Receive side takes its clock from outside |
| ser_clk_en | output | 1 | One-cycle serial clock enable pulse |
| tick_x16 | output | 1 | One-cycle 16x oversampling strobe (asynchronous mode) |
| sclk_out | output | 1 | Serial clock pin value, 50% duty |
| sclk_oe | output | 1 | Output enable for the serial clock pin |

## Verification
The divider chain is run at its extremes and at middle values: divide-by-1 with the prescaler bypassed, which gives the shortest legal period of two cycles; a middle ratio with the divide-by-8 prescaler, which separates the prescaler from the programmable divider; and the full 4096 ratio, which exposes a truncated or mis-sized counter. Each of the three pin modes is tried with the control bit that is meant to be ignored set to the opposite value, so that a wrong mode decode shows up as a wrong pin period rather than going unnoticed. A ratio change issued just after a pulse shows whether reloading waits for the terminal count: the expected interval is the old count plus the new count, and an immediate reload would shorten it. The period measured from reset release tells whether the counters start cleared.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  // Source of the serial clock pin toggle.
  typedef enum logic [1:0] {
    SRC_SER  = 2'd0,  // toggle on each serial clock pulse (synchronous)
    SRC_SLOW = 2'd1,  // toggle every OUT_DIV/2 serial pulses (1x bit rate)
    SRC_FAST = 2'd2   // toggle on each pre-halving pulse (16x bit rate)
  } sclk_src_e;

  function automatic sclk_src_e pick_src(input logic sync_m, input logic fast);
    if (sync_m)    return SRC_SER;
    else if (fast) return SRC_FAST;
    else           return SRC_SLOW;
  endfunction
endpackage

// File: rtl/sbg_prescaler.sv
module sbg_prescaler #(
  parameter int RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic hit
);
  localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [W-1:0] cnt;

  assign hit = (cnt == '0);

  // New selection takes effect only at terminal count.
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (hit) cnt <= sel ? W'(RATIO - 1) : '0;
    else          cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sbg_divider.sv
module sbg_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [DIV_W-1:0] ratio_m1,
  output logic             div_hit,
  output logic             ser_hit
);
  logic [DIV_W-1:0] dcnt;
  logic             half;

  assign div_hit = step && (dcnt == '0);
  assign ser_hit = div_hit && half;

  // Ratio is reloaded only when the count expires.
  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      half <= 1'b0;
    end else if (step) begin
      if (dcnt == '0) begin
        dcnt <= ratio_m1;
        half <= ~half;
      end else begin
        dcnt <= dcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbg_sclk_gen.sv
module sbg_sclk_gen
  import sbg_pkg::*;
#(
  parameter int OUT_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic div_hit,
  input  logic ser_hit,
  input  logic sync_m,
  input  logic fast,
  input  logic tx_ext,
  input  logic rx_ext,
  output logic en_q,
  output logic tick_q,
  output logic sclk_q,
  output logic oe_q
);
  localparam int HALF = OUT_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] ocnt;
  logic          ocnt_last;
  logic          tog;
  sclk_src_e     src;

  assign ocnt_last = (ocnt == CW'(HALF - 1));
  assign src       = pick_src(sync_m, fast);

  always_comb begin
    unique case (src)
      SRC_SER:  tog = ser_hit;
      SRC_SLOW: tog = ser_hit && ocnt_last;
      SRC_FAST: tog = div_hit;
      default:  tog = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt   <= '0;
      en_q   <= 1'b0;
      tick_q <= 1'b0;
      sclk_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (ser_hit) ocnt <= ocnt_last ? '0 : ocnt + 1'b1;
      en_q   <= ser_hit;
      tick_q <= ser_hit && !sync_m;
      if (tog) sclk_q <= ~sclk_q;
      oe_q   <= !(tx_ext || rx_ext);
    end
  end
endmodule

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
  parameter int DIV_W   = 12,
  parameter int PRE_DIV = 8,
  parameter int OUT_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             pre_sel,
  input  logic             out_fast,
  input  logic             sync_mode,
  input  logic             tx_ext_clk,
  input  logic             rx_ext_clk,
  output logic             ser_clk_en,
  output logic             tick_x16,
  output logic             sclk_out,
  output logic             sclk_oe
);
  logic any_rst;
  logic pre_hit;
  logic div_hit;
  logic ser_hit;

  assign any_rst = rst || soft_rst;

  sbg_prescaler #(.RATIO(PRE_DIV)) i_pre (
    .clk (clk),
    .rst (any_rst),
    .sel (pre_sel),
    .hit (pre_hit)
  );

  sbg_divider #(.DIV_W(DIV_W)) i_div (
    .clk      (clk),
    .rst      (any_rst),
    .step     (pre_hit),
    .ratio_m1 (div_ratio),
    .div_hit  (div_hit),
    .ser_hit  (ser_hit)
  );

  sbg_sclk_gen #(.OUT_DIV(OUT_DIV)) i_out (
    .clk     (clk),
    .rst     (any_rst),
    .div_hit (div_hit),
    .ser_hit (ser_hit),
    .sync_m  (sync_mode),
    .fast    (out_fast),
    .tx_ext  (tx_ext_clk),
    .rx_ext  (rx_ext_clk),
    .en_q    (ser_clk_en),
    .tick_q  (tick_x16),
    .sclk_q  (sclk_out),
    .oe_q    (sclk_oe)
  );
endmodule

// File: rtl/sci_baud_gen_chk.sv
module sci_baud_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic [DIV_W-1:0] div_ratio,
  input logic             pre_sel,
  input logic             out_fast,
  input logic             sync_mode,
  input logic             tx_ext_clk,
  input logic             rx_ext_clk,
  input logic             ser_clk_en,
  input logic             tick_x16,
  input logic             sclk_out,
  input logic             sclk_oe
);
  // R3: serial clock enable never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst || soft_rst)
    ser_clk_en |=> !ser_clk_en);

  // R4: tick only alongside a serial pulse, and only in asynchronous mode
  a_r4_tick_async: assert property (@(posedge clk) disable iff (rst || soft_rst)
    tick_x16 |-> (ser_clk_en && !$past(sync_mode)));

  // R5: in synchronous mode the pin moves only with a serial pulse
  a_r5_sync_hold: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (sync_mode && $past(sync_mode) && !$past(rst || soft_rst) && !ser_clk_en)
      |-> $stable(sclk_out));

  a_r5_sync_toggle: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (ser_clk_en && $past(sync_mode)) |-> (sclk_out != $past(sclk_out)));

  // R8: output enable follows both clock-source bits
  a_r8_oe_follow: assert property (@(posedge clk) disable iff (rst || soft_rst)
    1'b1 |=> (sclk_oe == !($past(tx_ext_clk) || $past(rx_ext_clk))));

  // R9: any reset clears every output
  a_r9_reset_clear: assert property (@(posedge clk)
    (rst || soft_rst) |=> (!ser_clk_en && !tick_x16 && !sclk_out && !sclk_oe));
endmodule

bind sci_baud_gen sci_baud_gen_chk #(.DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_sci_baud_gen.sv
module test_sci_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [11:0] div_ratio = '0;
  logic        pre_sel = 1'b0;
  logic        out_fast = 1'b0;
  logic        sync_mode = 1'b1;
  logic        tx_ext_clk = 1'b0;
  logic        rx_ext_clk = 1'b0;
  logic        ser_clk_en, tick_x16, sclk_out, sclk_oe;

  int checks = 0;
  int errors = 0;
  int en_q[$];
  int sc_q[$];
  string tag = "";
  int cyc = 0;
  int en_last = -1;
  int sc_last = -1;
  logic sc_prev = 1'b0;
  int tick_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sci_baud_gen i_sci_baud_gen (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .div_ratio(div_ratio),
    .pre_sel(pre_sel), .out_fast(out_fast), .sync_mode(sync_mode),
    .tx_ext_clk(tx_ext_clk), .rx_ext_clk(rx_ext_clk),
    .ser_clk_en(ser_clk_en), .tick_x16(tick_x16),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures pulse intervals and pin half periods, compares with queue
  always @(negedge clk) begin
    cyc++;
    if (rst || soft_rst) begin
      en_last = -1;
      sc_last = -1;
      sc_prev = 1'b0;
    end else begin
      if (sync_mode ? tick_x16 : (tick_x16 != ser_clk_en)) tick_bad++;
      if (ser_clk_en) begin
        if (en_last >= 0 && en_q.size() > 0) begin
          automatic int e = en_q.pop_front();
          chk((cyc - en_last) == e, {tag, " enable interval"}, cyc - en_last, e);
        end
        en_last = cyc;
      end
      if (sclk_out != sc_prev) begin
        if (sc_last >= 0 && sc_q.size() > 0) begin
          automatic int e = sc_q.pop_front();
          chk((cyc - sc_last) == e, {tag, " sclk half period"}, cyc - sc_last, e);
        end
        sc_last = cyc;
        sc_prev = sclk_out;
      end
    end
  end

  // Driver: configure, push expectations, release reset, wait for results
  task automatic run_cfg(input string t, input bit sm, input bit fast, input int n,
                         input bit ps, input int n_en, input int n_sc);
    automatic int p = ps ? 8 : 1;
    automatic int tp = 2 * p * (n + 1);
    automatic int hp = sm ? tp : (fast ? tp / 2 : 8 * tp);
    @(negedge clk);
    rst = 1'b1;
    sync_mode = sm; out_fast = fast; div_ratio = 12'(n); pre_sel = ps;
    @(negedge clk);
    @(negedge clk);
    en_q.delete();
    sc_q.delete();
    tag = t;
    for (int i = 0; i < n_en; i++) en_q.push_back(tp);
    for (int i = 0; i < n_sc; i++) sc_q.push_back(hp);
    tick_bad = 0;
    rst = 1'b0;
    while (en_q.size() != 0 || sc_q.size() != 0) @(negedge clk);
    chk(tick_bad == 0, {t, " R4 tick vs mode"}, tick_bad, 0);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", en_q.size() + sc_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: state during hardware reset
    @(negedge clk);
    @(negedge clk);
    chk({ser_clk_en, tick_x16, sclk_out, sclk_oe} == 4'b0, "R9 reset outputs",
        {ser_clk_en, tick_x16, sclk_out, sclk_oe}, 0);

    // R3 R5: shortest period, out_fast set but ignored in synchronous mode
    run_cfg("R3 R5 sync div1", 1'b1, 1'b1, 0, 1'b0, 3, 3);
    // R1 R2 R5: middle ratio with divide-by-8 prescaler
    run_cfg("R1 R2 R5 sync n4 pre8", 1'b1, 1'b0, 4, 1'b1, 3, 3);
    // R6 R4: asynchronous, 1x bit rate on the pin
    run_cfg("R6 async slow", 1'b0, 1'b0, 2, 1'b0, 3, 2);
    // R7 R4 R2: asynchronous, 16x on the pin
    run_cfg("R7 async fast pre8", 1'b0, 1'b1, 2, 1'b1, 3, 4);
    // R1: maximum ratio 4096
    run_cfg("R1 max ratio", 1'b1, 1'b0, 12'hFFF, 1'b0, 2, 1);

    // R10: change ratio just after a pulse; in-flight period keeps old count
    run_cfg("R10 before change", 1'b1, 1'b0, 3, 1'b0, 2, 0);
    @(negedge clk);
    div_ratio = 12'd1;
    tag = "R10 after change";
    en_q.push_back(6);
    en_q.push_back(4);
    while (en_q.size() != 0) @(negedge clk);

    // R9: software reset clears outputs, then restart timing
    @(negedge clk);
    soft_rst = 1'b1;
    div_ratio = 12'd1;
    pre_sel = 1'b1;
    @(negedge clk);
    chk({ser_clk_en, tick_x16, sclk_out, sclk_oe} == 4'b0, "R9 soft reset outputs",
        {ser_clk_en, tick_x16, sclk_out, sclk_oe}, 0);
    soft_rst = 1'b0;
    begin
      automatic int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!ser_clk_en && cnt < 100);
      chk(cnt == 17, "R9 first pulse after release", cnt, 17);
    end

    // R8: output enable versus clock-source bits
    tx_ext_clk = 1'b1; rx_ext_clk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(sclk_oe == 1'b0, "R8 tx external", sclk_oe, 0);
    tx_ext_clk = 1'b0; rx_ext_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sclk_oe == 1'b0, "R8 rx external", sclk_oe, 0);
    rx_ext_clk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(sclk_oe == 1'b1, "R8 both internal", sclk_oe, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule